// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block sits between a clock generator's configuration pins and its internal control logic. While the combined power-good/power-down pin is low, the configuration straps (four frequency-select bits, a pair-routing strap for the debug CPU clock, a pair-routing strap for the stop-control inputs, and a test-select level) are followed continuously. The pin rising marks the moment the supply is stable. The strap values held at that moment become the operating configuration. From then on the same pin is read as a live, active-low power-down request.

The pin is brought into the clock domain through a two-stage synchronizer. A rising edge of the synchronized level freezes the straps exactly once. After that, strap activity is ignored. The one exception is test mode, in which the straps keep tracking the pins. The frozen frequency code is also turned into a CPU frequency, given as an integer count of 100 kHz steps. A synchronous reset returns the block to its pre-capture state, so that a later power-up sequence can latch again.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `freq_code` is 0, `sel_cpu2_itp`, `sel_src5_pair`, `test_mode`, `test_ref_sel` and `pwrdn_req` are all 0, and no capture has taken place.
- R2: `pg_pin` passes through two synchronizer flops. A rise of `pg_pin` before clock edge k freezes the strap values present at edge k+2, which is the first edge at which the synchronized level differs from its delayed copy.
- R3: Before capture, the strap outputs follow the strap pins with one clock of latency: `freq_code` = {fs_d, fs_c, fs_b, fs_a}, `sel_cpu2_itp` = itp_strap and `sel_src5_pair` = src5_strap.
- R4: After capture and outside test mode, changes on fs_a..fs_d, itp_strap and src5_strap have no effect on `freq_code`, `sel_cpu2_itp` or `sel_src5_pair`.
- R5: `pwrdn_req` is 0 until capture. After capture it equals the inverse of the synchronized `pg_pin`, so it goes to 1 two edges after the pin goes low.
- R6: Once captured, a later fall and rise of `pg_pin` does not relatch the straps and does not change `test_mode`.
- R7: `sel_cpu2_itp` = 1 routes the shared differential pair to the debug CPU clock, and 0 routes it to the SRC8 clock. The value is the latched itp_strap.
- R8: `sel_src5_pair` = 1 gives the shared pins to the SRC5 clock, and 0 gives them to the two stop-control inputs. The value is the latched src5_strap.
- R9: `test_mode` becomes 1 exactly when `test_sel` is 1 at the capture edge. Later changes of `test_sel` have no effect on it.
- R10: In test mode, the strap outputs keep following the strap pins with one clock of latency.
- R11: `test_ref_sel` = `test_mode` AND latched fs_b. A value of 1 selects reference-divided output, and 0 selects tri-state. Outside test mode it is 0.
- R12: `cpu_freq` is in units of 100 kHz. The lower bits {fs_c,fs_b,fs_a} select from this list: 000→2666, 001→1333, 010→2000, 011→1666, 100→3333, 101→1000, 110→4000, 111→2000. When fs_d is 1, 9 is added to the selected value.
- R13: A synchronous reset clears the capture, and the next rise of `pg_pin` latches new strap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pg_pin | input | 1 | Power-good strobe, which becomes the active-low power-down input after capture |
| fs_a | input | 1 | Frequency select bit 0 |
| fs_b | input | 1 | Frequency select bit 1, which also picks the test output behaviour |
| fs_c | input | 1 | Frequency select bit 2 |
| fs_d | input | 1 | Frequency select bit 3 (+0.9 MHz offset) |
| itp_strap | input | 1 | Strap for routing the shared pair to the debug CPU clock |
| src5_strap | input | 1 | Strap for routing the shared pins to SRC5 |
| test_sel | input | 1 | Test-select level |
| freq_code | output | 4 | Latched {fs_d,fs_c,fs_b,fs_a} |
| cpu_freq | output | 16 | CPU frequency in 100 kHz units |
| sel_cpu2_itp | output | 1 | Mux select for the shared differential pair |
| sel_src5_pair | output | 1 | Mux select for the shared SRC5/stop pins |
| test_mode | output | 1 | Test mode is active |
| test_ref_sel | output | 1 | Test output choice: 1 = reference divided, 0 = tri-state |
| pwrdn_req | output | 1 | Real-time power-down request |

## Verification
Two functions can act on the same clock edge. The first is the freezing of the straps by the capture edge, which the bench provokes by changing the strap pins in the cycle just before that edge and again just after it. The second is the power-down reading of the pin, which the bench provokes by dropping the pin again within a couple of cycles of capture and then raising it once more. A reference model in the bench tracks the pin history and the capture state, and it is compared with every output on every clock. It must show the values present at the capture edge frozen, the ones that arrive one edge later ignored, `pwrdn_req` following the late drop, and no second capture when the pin rises again.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int FREQ_W    = 16;
    localparam int FS_BITS   = 4;
    localparam int FD_OFFSET = 9;   // +0.9 MHz in 100 kHz units

    typedef struct packed {
        logic [FS_BITS-1:0] fs;     // {d,c,b,a}
        logic               itp;
        logic               src5;
    } strap_t;

    function automatic logic [FREQ_W-1:0] freq_of(input logic [FS_BITS-1:0] code);
        logic [FREQ_W-1:0] base;
        unique case (code[2:0])
            3'b000:  base = FREQ_W'(2666);
            3'b001:  base = FREQ_W'(1333);
            3'b010:  base = FREQ_W'(2000);
            3'b011:  base = FREQ_W'(1666);
            3'b100:  base = FREQ_W'(3333);
            3'b101:  base = FREQ_W'(1000);
            3'b110:  base = FREQ_W'(4000);
            default: base = FREQ_W'(2000);
        endcase
        return code[3] ? base + FREQ_W'(FD_OFFSET) : base;
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [TOP:0] chain;
        logic         prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        if (STAGES > 1) begin
            sync_d.chain = {sync_q.chain[TOP-1:0], pin};
        end else begin
            sync_d.chain = TOP'(pin);
        end
        sync_d.prev = sync_q.chain[TOP];
        if (!rst_n) begin
            sync_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign level = sync_q.chain[TOP];
    assign rise  = sync_q.chain[TOP] & ~sync_q.prev;

endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rise,
    input  strap_t pins,
    input  logic   test_sel,
    output strap_t held,
    output logic   captured,
    output logic   tmode
);
    typedef struct packed {
        strap_t lat;
        logic   cap;
        logic   tm;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        // straps stay transparent until frozen, and again in test mode
        if (!cap_q.cap || cap_q.tm) begin
            cap_d.lat = pins;
        end
        if (rise && !cap_q.cap) begin
            cap_d.cap = 1'b1;
            cap_d.tm  = test_sel;
        end
        if (!rst_n) begin
            cap_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign held     = cap_q.lat;
    assign captured = cap_q.cap;
    assign tmode    = cap_q.tm;

endmodule

// File: rtl/freq_lookup.sv
module freq_lookup
    import strap_pkg::*;
(
    input  logic [FS_BITS-1:0] code,
    output logic [FREQ_W-1:0]  freq
);
    always_comb begin
        freq = freq_of(code);
    end
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_pin,
    input  logic              fs_a,
    input  logic              fs_b,
    input  logic              fs_c,
    input  logic              fs_d,
    input  logic              itp_strap,
    input  logic              src5_strap,
    input  logic              test_sel,
    output logic [3:0]        freq_code,
    output logic [15:0]       cpu_freq,
    output logic              sel_cpu2_itp,
    output logic              sel_src5_pair,
    output logic              test_mode,
    output logic              test_ref_sel,
    output logic              pwrdn_req
);
    logic   pg_level;
    logic   pg_rise;
    logic   cap_flag;
    strap_t pin_vec;
    strap_t held;
    logic [FREQ_W-1:0] freq_w;

    assign pin_vec = '{fs: {fs_d, fs_c, fs_b, fs_a}, itp: itp_strap, src5: src5_strap};

    pg_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pg_pin),
        .level (pg_level),
        .rise  (pg_rise)
    );

    strap_capture i_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (pg_rise),
        .pins     (pin_vec),
        .test_sel (test_sel),
        .held     (held),
        .captured (cap_flag),
        .tmode    (test_mode)
    );

    freq_lookup i_lut (
        .code (held.fs),
        .freq (freq_w)
    );

    assign freq_code     = held.fs;
    assign cpu_freq      = 16'(freq_w);
    assign sel_cpu2_itp  = held.itp;
    assign sel_src5_pair = held.src5;
    assign test_ref_sel  = test_mode & held.fs[1];
    assign pwrdn_req     = cap_flag & ~pg_level;

endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        captured,
    input logic        test_mode,
    input logic        pwrdn_req,
    input logic        test_ref_sel,
    input logic        sel_cpu2_itp,
    input logic        sel_src5_pair,
    input logic [3:0]  freq_code,
    input logic [15:0] cpu_freq
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!captured && !test_mode && !pwrdn_req && freq_code == 4'd0));

    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && $past(captured) && !test_mode)
            |-> $stable({freq_code, sel_cpu2_itp, sel_src5_pair}));

    a_r5_pd_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_req |-> captured);

    a_r6_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        captured |=> captured);

    a_r9_tm_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> $rose(captured));

    a_r11_ref_in_test: assert property (@(posedge clk) disable iff (!rst_n)
        test_ref_sel |-> test_mode);

    a_r12_freq_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_freq >= 16'd1000 && cpu_freq <= 16'd4009));

endmodule

bind strap_latch_ctrl strap_latch_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .captured      (cap_flag),
    .test_mode     (test_mode),
    .pwrdn_req     (pwrdn_req),
    .test_ref_sel  (test_ref_sel),
    .sel_cpu2_itp  (sel_cpu2_itp),
    .sel_src5_pair (sel_src5_pair),
    .freq_code     (freq_code),
    .cpu_freq      (cpu_freq)
);

// File: tb/test_strap_latch_ctrl.sv
module test_strap_latch_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg_pin = 1'b0;
    logic fs_a = 1'b0, fs_b = 1'b0, fs_c = 1'b0, fs_d = 1'b0;
    logic itp_strap = 1'b0, src5_strap = 1'b0, test_sel = 1'b0;
    logic [3:0]  freq_code;
    logic [15:0] cpu_freq;
    logic sel_cpu2_itp, sel_src5_pair, test_mode, test_ref_sel, pwrdn_req;

    int n_checks = 0;
    int n_errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    strap_latch_ctrl i_strap_latch_ctrl (
        .clk(clk), .rst_n(rst_n), .pg_pin(pg_pin),
        .fs_a(fs_a), .fs_b(fs_b), .fs_c(fs_c), .fs_d(fs_d),
        .itp_strap(itp_strap), .src5_strap(src5_strap), .test_sel(test_sel),
        .freq_code(freq_code), .cpu_freq(cpu_freq),
        .sel_cpu2_itp(sel_cpu2_itp), .sel_src5_pair(sel_src5_pair),
        .test_mode(test_mode), .test_ref_sel(test_ref_sel), .pwrdn_req(pwrdn_req)
    );

    // ---------------- reference model ----------------
    bit pg_hist[$];           // pin values seen at past edges, newest last
    bit m_cap, m_tm, m_itp, m_src5;
    int m_code;

    function automatic int ref_freq(int code);
        int base_tab[8] = '{2666, 1333, 2000, 1666, 3333, 1000, 4000, 2000};
        return base_tab[code % 8] + ((code >= 8) ? 9 : 0);
    endfunction

    function automatic bit seen(int back);   // pin value `back` edges ago
        if (pg_hist.size() < back) return 1'b0;
        return pg_hist[pg_hist.size() - back];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pg_hist.delete();
            m_cap = 0; m_tm = 0; m_itp = 0; m_src5 = 0; m_code = 0;
        end else begin
            bit edge_seen;
            edge_seen = seen(2) && !seen(3) && !m_cap;
            if (!m_cap || m_tm) begin
                m_code = {fs_d, fs_c, fs_b, fs_a};
                m_itp  = itp_strap;
                m_src5 = src5_strap;
            end
            if (edge_seen) begin
                m_cap = 1;
                m_tm  = test_sel;
            end
            pg_hist.push_back(pg_pin);
            if (pg_hist.size() > 4) void'(pg_hist.pop_front());
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R3/R4/R10 freq_code", freq_code, m_code);
            check("R12 cpu_freq", cpu_freq, ref_freq(m_code));
            check("R7 sel_cpu2_itp", sel_cpu2_itp, m_itp);
            check("R8 sel_src5_pair", sel_src5_pair, m_src5);
            check("R9 test_mode", test_mode, m_tm);
            check("R11 test_ref_sel", test_ref_sel, m_tm & m_code[1]);
            check("R5 pwrdn_req", pwrdn_req, m_cap & !seen(2));
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_straps(int code, bit itp, bit src5);
        {fs_d, fs_c, fs_b, fs_a} = code[3:0];
        itp_strap  = itp;
        src5_strap = src5;
    endtask

    task automatic do_reset();
        rst_n = 0; pg_pin = 0;
        cyc(2);
        rst_n = 1;
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        set_straps(4'b1011, 1, 1);
        test_sel = 0;
        cyc(1);
        cmp_on = 1;
        cyc(1);
        // R1: outputs cleared while reset held, despite non-zero straps
        check("R1 freq_code", freq_code, 0);
        check("R1 pwrdn_req", pwrdn_req, 0);
        check("R1 test_mode", test_mode, 0);
        rst_n = 1;

        // R3: pre-capture straps track pins
        for (int i = 0; i < 6; i++) begin
            set_straps(i * 3, i[0], i[1]);
            cyc(1);
        end

        // R2: rise the pin, straps at 3rd edge get frozen, later ones ignored
        set_straps(4'b0101, 1, 0);
        pg_pin = 1;
        cyc(2);
        set_straps(4'b0110, 0, 1);   // present at capture edge -> frozen
        cyc(1);
        set_straps(4'b0011, 1, 1);   // arrives after capture -> ignored (R4)
        cyc(2);
        check("R2 frozen code", freq_code, 4'b0110);
        check("R4 ignored itp", sel_cpu2_itp, 0);
        check("R12 400MHz", cpu_freq, 4000);

        // R5: pin low -> power-down request two edges later
        pg_pin = 0;
        cyc(1);
        check("R5 not yet", pwrdn_req, 0);
        cyc(1);
        check("R5 asserted", pwrdn_req, 1);
        // R6: rise again with new straps, no relatch
        set_straps(4'b1111, 0, 0);
        test_sel = 1;
        pg_pin = 1;
        cyc(6);
        check("R6 no relatch", freq_code, 4'b0110);
        check("R6 no test mode", test_mode, 0);
        check("R5 released", pwrdn_req, 0);

        // R13: reset allows a new capture, this time in test mode (R9)
        do_reset();
        set_straps(4'b1101, 1, 0);
        test_sel = 1;
        pg_pin = 1;
        cyc(4);
        check("R13 new capture", freq_code, 4'b1101);
        check("R9 test mode", test_mode, 1);
        check("R11 tri-state", test_ref_sel, 0);
        test_sel = 0;
        set_straps(4'b1111, 0, 1);   // R10: keeps tracking
        cyc(2);
        check("R10 tracking", freq_code, 4'b1111);
        check("R11 ref div", test_ref_sel, 1);
        check("R9 sticky", test_mode, 1);
        pg_pin = 0;
        cyc(3);

        // R12 sweep of all codes, with a quick drop after capture
        for (int c = 0; c < 16; c++) begin
            do_reset();
            test_sel = 0;
            set_straps(c, c[2], c[0]);
            pg_pin = 1;
            cyc(3);
            set_straps(15 - c, !c[2], !c[0]);
            pg_pin = 0;
            cyc(2);
            pg_pin = 1;
            cyc(3);
            check("R12 sweep", cpu_freq, ref_freq(c));
        end

        cyc(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule